// File: doc/BRIEF.md
# Partitionable Two-Way Set-Associative Cache

This block is a small read cache with two ways. A mode register decides how the ways are used. In shared mode, port 0 owns both ways and sees an ordinary two-way set-associative cache with least-recently-used replacement in each set. In split mode, each way becomes a private direct-mapped cache: way 0 serves port 0 and way 1 serves port 1, and the two ports look up, miss and refill at the same time without affecting each other. Both modes use the same address split: word offset in the low bits, then set index, then tag.

Every lookup answers one cycle after the request, with a hit and the word, or with a miss. A miss raises a one-cycle line request on that port's refill interface. The port then waits for the line to come back. When it arrives the line is installed, and the original lookup replays and answers as a hit in the following cycle. Writing the mode register discards every cached line and any outstanding miss.

Top module: `pcache_top`

## Requirements
- R1: After reset the block is in shared mode with every line invalid. No port shows hit, miss or line request, and the first lookup of any address misses.
- R2: The address splits into fields. The low OFF_W bits pick a word, and word k sits at bits [k*WORD_W +: WORD_W] of a line. The next IDX_W bits pick the set and the remaining high bits form the tag. The line address is the request address shifted right by OFF_W.
- R3: A request accepted at one clock edge gives exactly one of hit or miss in the next cycle. On a hit, the data output carries the addressed word.
- R4: On a miss, the port raises its line request with the line address in the same cycle as the miss, for one cycle only.
- R5: A refill return on a port with a miss outstanding installs the line. In the next cycle the port reports a hit with the originally requested word, and later lookups of that line hit.
- R6: A request made while the port has a miss outstanding, including the cycle that reports the miss, is dropped and gets no response. A refill return with no miss outstanding changes nothing.
- R7: In shared mode, two lines of the same set stay resident together, and all port 1 inputs are ignored, so its hit, miss and line request outputs stay low.
- R8: In shared mode, a miss in a set whose ways are both valid replaces the way used least recently, where a hit and a refill both count as a use. Otherwise it fills an empty way.
- R9: In split mode, port 0 uses only way 0 and port 1 uses only way 1. Each acts direct-mapped, so two lines of one set on the same port evict each other.
- R10: In split mode, a line installed through one port never produces a hit on the other port, even for the same address.
- R11: A write of the mode register (cfg_split 0 = shared, 1 = split) invalidates every line and drops any outstanding miss. Neither port reports hit or miss in the next cycle.
- R12: In split mode, both ports can look up, miss and refill in the same cycles, each with its own result and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write the mode register |
| cfg_split | input | 1 | Mode value: 0 shared, 1 split |
| p0_req | input | 1 | Port 0 lookup request |
| p0_addr | input | ADDR_W | Port 0 lookup address |
| p0_hit | output | 1 | Port 0 hit response |
| p0_miss | output | 1 | Port 0 miss response |
| p0_rdata | output | WORD_W | Port 0 word on hit |
| p0_fill_req | output | 1 | Port 0 line request |
| p0_fill_addr | output | ADDR_W-OFF_W | Port 0 requested line address |
| p0_fill_valid | input | 1 | Port 0 line return strobe |
| p0_fill_data | input | WORDS*WORD_W | Port 0 returned line |
| p1_req | input | 1 | Port 1 lookup request |
| p1_addr | input | ADDR_W | Port 1 lookup address |
| p1_hit | output | 1 | Port 1 hit response |
| p1_miss | output | 1 | Port 1 miss response |
| p1_rdata | output | WORD_W | Port 1 word on hit |
| p1_fill_req | output | 1 | Port 1 line request |
| p1_fill_addr | output | ADDR_W-OFF_W | Port 1 requested line address |
| p1_fill_valid | input | 1 | Port 1 line return strobe |
| p1_fill_data | input | WORDS*WORD_W | Port 1 returned line |

## Verification
The assertions assume that a line return comes at least one cycle after the cycle that raised the line request, and that its data belongs to the line that was asked for. They also assume that mode writes arrive while no lookup is expected to complete. The stimulus keeps to these assumptions: refills are always driven in a cycle after the miss was sampled, and mode writes are made only between transactions. Dropped requests and stray refill returns are issued on purpose, since the block must tolerate both.

// File: rtl/pcache_pkg.sv
package pcache_pkg;

  typedef enum logic {
    MODE_SHARED = 1'b0,
    MODE_SPLIT  = 1'b1
  } pc_mode_e;

  // Way chosen for a refill: a single allowed way wins outright,
  // otherwise an empty way, otherwise the set's LRU victim.
  function automatic logic pick_victim(input logic [1:0] mask,
                                       input logic [1:0] vld,
                                       input logic       lru);
    logic v;
    case (mask)
      2'b01:   v = 1'b0;
      2'b10:   v = 1'b1;
      default: begin
        if (!vld[0])      v = 1'b0;
        else if (!vld[1]) v = 1'b1;
        else              v = lru;
      end
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pcache_way.sv
module pcache_way #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 7,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inval,
  input  logic [IDX_W-1:0]  idx,
  input  logic [TAG_W-1:0]  tag,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  output logic              hit,
  output logic              vld,
  output logic [LINE_W-1:0] line
);

  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   vld_q;
  logic [SETS-1:0]   vld_d;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_comb begin
    vld_d = vld_q;
    if (inval) begin
      vld_d = '0;
    end else if (wr_en) begin
      vld_d[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // Tag and data storage carry no reset; the valid bits guard them.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[idx]  <= tag;
      line_q[idx] <= wr_line;
    end
  end

  assign vld  = vld_q[idx];
  assign hit  = vld_q[idx] && (tag_q[idx] == tag);
  assign line = line_q[idx];

endmodule

// File: rtl/pcache_lru.sv
module pcache_lru #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [IDX_W-1:0] idx,
  input  logic             upd_en,
  input  logic             upd_victim,
  output logic             victim
);

  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] lru_q;
  logic [SETS-1:0] lru_d;

  always_comb begin
    lru_d = lru_q;
    if (clr) begin
      lru_d = '0;
    end else if (upd_en) begin
      lru_d[idx] = upd_victim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else begin
      lru_q <= lru_d;
    end
  end

  assign victim = lru_q[idx];

endmodule

// File: rtl/pcache_port.sv
module pcache_port
  import pcache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2,
  parameter int WORD_W = 16,
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W = (1 << OFF_W) * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               clr,
  input  logic               req,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               fill_valid,
  input  logic [1:0]         way_mask,
  input  logic [1:0]         way_hit,
  input  logic [1:0]         way_vld,
  input  logic [LINE_W-1:0]  line0,
  input  logic [LINE_W-1:0]  line1,
  input  logic               lru_victim,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [TAG_W-1:0]   lk_tag,
  output logic               hit,
  output logic               miss,
  output logic [WORD_W-1:0]  rdata,
  output logic               fill_req,
  output logic [ADDR_W-OFF_W-1:0] fill_addr,
  output logic               wr_en,
  output logic               wr_way
);

  logic              stg_v_q, stg_v_d;
  logic [ADDR_W-1:0] stg_a_q;
  logic              pend_q, pend_d;
  logic              vic_q, vic_d;
  logic              accept;
  logic              any_hit;
  logic              from_w1;
  logic [LINE_W-1:0] sel_line;
  logic [OFF_W-1:0]  woff;

  assign lk_idx = stg_a_q[OFF_W +: IDX_W];
  assign lk_tag = stg_a_q[ADDR_W-1 -: TAG_W];
  assign woff   = stg_a_q[OFF_W-1:0];

  always_comb begin
    any_hit   = |(way_hit & way_mask);
    from_w1   = way_hit[1] & way_mask[1];
    hit       = stg_v_q & any_hit;
    miss      = stg_v_q & ~any_hit;
    sel_line  = from_w1 ? line1 : line0;
    rdata     = hit ? sel_line[woff*WORD_W +: WORD_W] : '0;
    fill_req  = miss;
    fill_addr = stg_a_q[ADDR_W-1:OFF_W];
    wr_en     = pend_q & fill_valid & ~clr;
    wr_way    = vic_q;
  end

  // next state
  always_comb begin
    accept  = en & req & ~pend_q & ~miss & ~clr;
    stg_v_d = accept | wr_en;
    pend_d  = pend_q ? ~fill_valid : miss;
    vic_d   = miss ? pick_victim(way_mask, way_vld, lru_victim) : vic_q;
    if (clr || !en) begin
      stg_v_d = 1'b0;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      stg_v_q <= stg_v_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      stg_a_q <= addr;
    end
    vic_q <= vic_d;
  end

endmodule

// File: rtl/pcache_top.sv
module pcache_top
  import pcache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SETS   = 8,
  parameter int WORDS  = 4,
  parameter int WORD_W = 16,
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W = WORDS * WORD_W,
  localparam int LA_W   = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_split,
  input  logic              p0_req,
  input  logic [ADDR_W-1:0] p0_addr,
  output logic              p0_hit,
  output logic              p0_miss,
  output logic [WORD_W-1:0] p0_rdata,
  output logic              p0_fill_req,
  output logic [LA_W-1:0]   p0_fill_addr,
  input  logic              p0_fill_valid,
  input  logic [LINE_W-1:0] p0_fill_data,
  input  logic              p1_req,
  input  logic [ADDR_W-1:0] p1_addr,
  output logic              p1_hit,
  output logic              p1_miss,
  output logic [WORD_W-1:0] p1_rdata,
  output logic              p1_fill_req,
  output logic [LA_W-1:0]   p1_fill_addr,
  input  logic              p1_fill_valid,
  input  logic [LINE_W-1:0] p1_fill_data
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q = rst_sync_q[1];

  // mode register
  pc_mode_e mode_q, mode_d;
  logic     split_q;

  always_comb begin
    mode_d = mode_q;
    if (cfg_we) begin
      mode_d = cfg_split ? MODE_SPLIT : MODE_SHARED;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      mode_q <= MODE_SHARED;
    end else begin
      mode_q <= mode_d;
    end
  end
  assign split_q = (mode_q == MODE_SPLIT);

  // per-port lookup and write signals
  logic [IDX_W-1:0] p0_idx, p1_idx;
  logic [TAG_W-1:0] p0_tag, p1_tag;
  logic             p0_wr_en, p1_wr_en;
  logic             p0_wr_way, p1_wr_way;
  logic             lru_vic;

  // per-way routed signals
  logic [IDX_W-1:0]  w_idx  [2];
  logic [TAG_W-1:0]  w_tag  [2];
  logic [LINE_W-1:0] w_wdat [2];
  logic [LINE_W-1:0] w_line [2];
  logic [1:0]        w_we;
  logic [1:0]        w_hit;
  logic [1:0]        w_vld;

  always_comb begin
    w_idx[0]  = p0_idx;
    w_tag[0]  = p0_tag;
    w_wdat[0] = p0_fill_data;
    w_we[0]   = p0_wr_en & ~p0_wr_way;
    if (split_q) begin
      w_idx[1]  = p1_idx;
      w_tag[1]  = p1_tag;
      w_wdat[1] = p1_fill_data;
      w_we[1]   = p1_wr_en & p1_wr_way;
    end else begin
      w_idx[1]  = p0_idx;
      w_tag[1]  = p0_tag;
      w_wdat[1] = p0_fill_data;
      w_we[1]   = p0_wr_en & p0_wr_way;
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_way
    pcache_way #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .LINE_W(LINE_W)
    ) u_way (
      .clk    (clk),
      .rst_n  (rst_q),
      .inval  (cfg_we),
      .idx    (w_idx[w]),
      .tag    (w_tag[w]),
      .wr_en  (w_we[w]),
      .wr_line(w_wdat[w]),
      .hit    (w_hit[w]),
      .vld    (w_vld[w]),
      .line   (w_line[w])
    );
  end

  // replacement state, used in shared mode only
  logic lru_upd_en, lru_upd_vic;

  always_comb begin
    lru_upd_en  = ~split_q & (p0_hit | p0_wr_en);
    lru_upd_vic = p0_wr_en ? ~p0_wr_way : ~w_hit[1];
  end

  pcache_lru #(.IDX_W(IDX_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_q),
    .clr       (cfg_we),
    .idx       (p0_idx),
    .upd_en    (lru_upd_en),
    .upd_victim(lru_upd_vic),
    .victim    (lru_vic)
  );

  logic [1:0] p0_mask, p1_mask;
  assign p0_mask = split_q ? 2'b01 : 2'b11;
  assign p1_mask = split_q ? 2'b10 : 2'b00;

  pcache_port #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WORD_W(WORD_W)
  ) u_port0 (
    .clk       (clk),
    .rst_n     (rst_q),
    .en        (1'b1),
    .clr       (cfg_we),
    .req       (p0_req),
    .addr      (p0_addr),
    .fill_valid(p0_fill_valid),
    .way_mask  (p0_mask),
    .way_hit   (w_hit),
    .way_vld   (w_vld),
    .line0     (w_line[0]),
    .line1     (w_line[1]),
    .lru_victim(lru_vic),
    .lk_idx    (p0_idx),
    .lk_tag    (p0_tag),
    .hit       (p0_hit),
    .miss      (p0_miss),
    .rdata     (p0_rdata),
    .fill_req  (p0_fill_req),
    .fill_addr (p0_fill_addr),
    .wr_en     (p0_wr_en),
    .wr_way    (p0_wr_way)
  );

  pcache_port #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WORD_W(WORD_W)
  ) u_port1 (
    .clk       (clk),
    .rst_n     (rst_q),
    .en        (split_q),
    .clr       (cfg_we),
    .req       (p1_req),
    .addr      (p1_addr),
    .fill_valid(p1_fill_valid),
    .way_mask  (p1_mask),
    .way_hit   ({w_hit[1], 1'b0}),
    .way_vld   ({w_vld[1], 1'b1}),
    .line0     ('0),
    .line1     (w_line[1]),
    .lru_victim(1'b1),
    .lk_idx    (p1_idx),
    .lk_tag    (p1_tag),
    .hit       (p1_hit),
    .miss      (p1_miss),
    .rdata     (p1_rdata),
    .fill_req  (p1_fill_req),
    .fill_addr (p1_fill_addr),
    .wr_en     (p1_wr_en),
    .wr_way    (p1_wr_way)
  );

endmodule

// File: rtl/pcache_chk.sv
module pcache_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic split_mode,
  input logic p0_req,
  input logic p0_hit,
  input logic p0_miss,
  input logic p0_fill_req,
  input logic p0_fill_valid,
  input logic p1_req,
  input logic p1_hit,
  input logic p1_miss,
  input logic p1_fill_req,
  input logic p1_fill_valid
);

  // outstanding-miss trackers seen from the ports
  logic out0_q, out1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out0_q <= 1'b0;
      out1_q <= 1'b0;
    end else begin
      if (cfg_we)             out0_q <= 1'b0;
      else if (p0_fill_req)   out0_q <= 1'b1;
      else if (p0_fill_valid) out0_q <= 1'b0;
      if (cfg_we)             out1_q <= 1'b0;
      else if (p1_fill_req)   out1_q <= 1'b1;
      else if (p1_fill_valid) out1_q <= 1'b0;
    end
  end

  // R3
  p0_resp_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p0_req && !out0_q && !p0_miss && !cfg_we |=> (p0_hit ^ p0_miss));

  // R3
  p0_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({p0_hit, p0_miss}));

  // R12
  p1_resp_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_mode && p1_req && !out1_q && !p1_miss && !cfg_we |=> (p1_hit ^ p1_miss));

  // R4
  p0_fill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p0_fill_req |=> !p0_fill_req);

  // R4
  p1_fill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p1_fill_req |=> !p1_fill_req);

  // R5
  p0_refill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out0_q && p0_fill_valid && !cfg_we |=> p0_hit);

  // R5
  p1_refill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out1_q && p1_fill_valid && !cfg_we |=> p1_hit);

  // R6
  p0_wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out0_q && !p0_fill_valid |=> !p0_hit && !p0_miss);

  // R7
  p1_idle_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !split_mode |-> !p1_hit && !p1_miss && !p1_fill_req);

  // R11
  cfg_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !p0_hit && !p0_miss && !p1_hit && !p1_miss);

endmodule

bind pcache_top pcache_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_q),
  .cfg_we       (cfg_we),
  .split_mode   (split_q),
  .p0_req       (p0_req),
  .p0_hit       (p0_hit),
  .p0_miss      (p0_miss),
  .p0_fill_req  (p0_fill_req),
  .p0_fill_valid(p0_fill_valid),
  .p1_req       (p1_req),
  .p1_hit       (p1_hit),
  .p1_miss      (p1_miss),
  .p1_fill_req  (p1_fill_req),
  .p1_fill_valid(p1_fill_valid)
);

// File: tb/tb_pcache_top.sv
`timescale 1ns/1ps
module tb_pcache_top;

  localparam int ADDR_W = 12;
  localparam int SETS   = 8;
  localparam int WORDS  = 4;
  localparam int WORD_W = 16;
  localparam int IDX_W  = 3;
  localparam int OFF_W  = 2;
  localparam int LINE_W = WORDS * WORD_W;
  localparam int LA_W   = ADDR_W - OFF_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_split = 1'b0;
  logic p0_req = 1'b0, p1_req = 1'b0;
  logic [ADDR_W-1:0] p0_addr = '0, p1_addr = '0;
  logic p0_hit, p0_miss, p1_hit, p1_miss, p0_fill_req, p1_fill_req;
  logic [WORD_W-1:0] p0_rdata, p1_rdata;
  logic [LA_W-1:0] p0_fill_addr, p1_fill_addr;
  logic p0_fill_valid = 1'b0, p1_fill_valid = 1'b0;
  logic [LINE_W-1:0] p0_fill_data = '0, p1_fill_data = '0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pcache_top #(.ADDR_W(ADDR_W), .SETS(SETS), .WORDS(WORDS), .WORD_W(WORD_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_split(cfg_split),
    .p0_req(p0_req), .p0_addr(p0_addr), .p0_hit(p0_hit), .p0_miss(p0_miss),
    .p0_rdata(p0_rdata), .p0_fill_req(p0_fill_req), .p0_fill_addr(p0_fill_addr),
    .p0_fill_valid(p0_fill_valid), .p0_fill_data(p0_fill_data),
    .p1_req(p1_req), .p1_addr(p1_addr), .p1_hit(p1_hit), .p1_miss(p1_miss),
    .p1_rdata(p1_rdata), .p1_fill_req(p1_fill_req), .p1_fill_addr(p1_fill_addr),
    .p1_fill_valid(p1_fill_valid), .p1_fill_data(p1_fill_data)
  );

  function automatic int mk_addr(input int tag, input int set, input int off);
    return (tag << (IDX_W + OFF_W)) | (set << OFF_W) | off;
  endfunction

  // word k of line la as returned on the refill side of partition part
  function automatic logic [WORD_W-1:0] exp_word(input int la, input int k, input int part);
    return WORD_W'((la * 37 + k * 5 + 16'h0123) ^ (part != 0 ? 16'h5A5A : 16'h0000));
  endfunction

  function automatic logic [LINE_W-1:0] mk_line(input int la, input int part);
    logic [LINE_W-1:0] l;
    for (int k = 0; k < WORDS; k++) l[k*WORD_W +: WORD_W] = exp_word(la, k, part);
    return l;
  endfunction

  task automatic chk(input string r, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic longint o_hit(input int p);  return p == 0 ? p0_hit : p1_hit; endfunction
  function automatic longint o_miss(input int p); return p == 0 ? p0_miss : p1_miss; endfunction
  function automatic longint o_dat(input int p);  return p == 0 ? p0_rdata : p1_rdata; endfunction
  function automatic longint o_freq(input int p); return p == 0 ? p0_fill_req : p1_fill_req; endfunction
  function automatic longint o_fadr(input int p); return p == 0 ? p0_fill_addr : p1_fill_addr; endfunction

  task automatic drive_req(input int p, input int a);
    if (p == 0) begin p0_req = 1'b1; p0_addr = ADDR_W'(a); end
    else        begin p1_req = 1'b1; p1_addr = ADDR_W'(a); end
  endtask

  task automatic drop_req();
    p0_req = 1'b0;
    p1_req = 1'b0;
  endtask

  task automatic drive_fill(input int p, input int la, input int part);
    if (p == 0) begin p0_fill_valid = 1'b1; p0_fill_data = mk_line(la, part); end
    else        begin p1_fill_valid = 1'b1; p1_fill_data = mk_line(la, part); end
  endtask

  task automatic drop_fill();
    p0_fill_valid = 1'b0;
    p1_fill_valid = 1'b0;
  endtask

  // one lookup; on an expected miss, serve the refill and check the replay
  task automatic read(input int p, input int a, input bit exp_hit, input int part, input string r);
    int la, k;
    la = a >> OFF_W;
    k  = a & (WORDS - 1);
    @(negedge clk);
    drive_req(p, a);
    @(negedge clk);
    drop_req();
    if (exp_hit) begin
      chk({r, " hit"}, o_hit(p), 1);
      chk({r, " data"}, o_dat(p), exp_word(la, k, part));
    end else begin
      chk({r, " miss"}, o_miss(p), 1);
      chk({r, " R4 fill_req"}, o_freq(p), 1);
      chk({r, " R2 fill_addr"}, o_fadr(p), la);
      @(negedge clk);
      chk({r, " R4 single pulse"}, o_freq(p), 0);
      drive_fill(p, la, part);
      @(negedge clk);
      drop_fill();
      chk({r, " R5 replay hit"}, o_hit(p), 1);
      chk({r, " R5 replay data"}, o_dat(p), exp_word(la, k, part));
    end
  endtask

  task automatic write_mode(input bit split);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_split = split;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R11 p0 quiet", o_hit(0) | o_miss(0), 0);
    chk("R11 p1 quiet", o_hit(1) | o_miss(1), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int xa, ya;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 p0 outputs", {p0_hit, p0_miss, p0_fill_req}, 0);
    chk("R1 p1 outputs", {p1_hit, p1_miss, p1_fill_req}, 0);

    // R7 port 1 ignored in shared mode
    @(negedge clk);
    drive_req(1, mk_addr(3, 2, 1));
    @(negedge clk);
    drop_req();
    chk("R7 p1 silent", {p1_hit, p1_miss, p1_fill_req}, 0);
    chk("R7 p0 untouched", {p0_hit, p0_miss}, 0);

    // shared sweep: two tags per set, every word (R1, R2, R7)
    for (int s = 0; s < SETS; s++) begin
      read(0, mk_addr(s + 1, s, 1), 1'b0, 0, "R1");
      read(0, mk_addr(s + 9, s, 2), 1'b0, 0, "R7");
    end
    for (int s = 0; s < SETS; s++) begin
      for (int o = 0; o < WORDS; o++) begin
        read(0, mk_addr(s + 1, s, o), 1'b1, 0, "R7");
        read(0, mk_addr(s + 9, s, o), 1'b1, 0, "R2");
      end
    end

    // R8 LRU in set 0: tags 1, 9 resident, 9 most recent
    read(0, mk_addr(1, 0, 0), 1'b1, 0, "R8");
    read(0, mk_addr(17, 0, 0), 1'b0, 0, "R8");
    read(0, mk_addr(1, 0, 3), 1'b1, 0, "R8");
    read(0, mk_addr(9, 0, 1), 1'b0, 0, "R8");
    read(0, mk_addr(1, 0, 2), 1'b1, 0, "R8");
    read(0, mk_addr(17, 0, 1), 1'b0, 0, "R8");

    // R6 request during outstanding miss is dropped
    xa = mk_addr(20, 3, 0);
    ya = mk_addr(4, 3, 1);
    @(negedge clk);
    drive_req(0, xa);
    @(negedge clk);
    chk("R6 miss", p0_miss, 1);
    drive_req(0, ya);
    @(negedge clk);
    drop_req();
    chk("R6 dropped request silent", {p0_hit, p0_miss}, 0);
    drive_fill(0, xa >> OFF_W, 0);
    @(negedge clk);
    drop_fill();
    chk("R6 replay is original", p0_rdata, exp_word(xa >> OFF_W, 0, 0));
    // stray refill return with nothing outstanding
    @(negedge clk);
    p0_fill_valid = 1'b1;
    p0_fill_data = '1;
    @(negedge clk);
    p0_fill_valid = 1'b0;
    chk("R6 stray fill silent", {p0_hit, p0_miss}, 0);
    read(0, xa | 3, 1'b1, 0, "R6");

    // R11 mode write flushes, then split mode
    write_mode(1'b1);
    read(0, mk_addr(1, 0, 0), 1'b0, 0, "R11");

    // R10 isolation: same address misses on port 1
    read(1, mk_addr(1, 0, 0), 1'b0, 1, "R10");

    // R12 simultaneous hits with partition-private data
    @(negedge clk);
    drive_req(0, mk_addr(1, 0, 2));
    drive_req(1, mk_addr(1, 0, 2));
    @(negedge clk);
    drop_req();
    chk("R12 p0 hit", p0_hit, 1);
    chk("R12 p0 data", p0_rdata, exp_word(mk_addr(1, 0, 0) >> OFF_W, 2, 0));
    chk("R12 p1 hit", p1_hit, 1);
    chk("R12 p1 data", p1_rdata, exp_word(mk_addr(1, 0, 0) >> OFF_W, 2, 1));

    // R9 direct-mapped eviction on port 0, port 1 unaffected
    read(0, mk_addr(9, 0, 0), 1'b0, 0, "R9");
    read(0, mk_addr(1, 0, 1), 1'b0, 0, "R9");
    read(1, mk_addr(1, 0, 3), 1'b1, 1, "R10");

    // R12 simultaneous misses and refills
    @(negedge clk);
    drive_req(0, mk_addr(50, 5, 1));
    drive_req(1, mk_addr(60, 6, 2));
    @(negedge clk);
    drop_req();
    chk("R12 p0 miss", p0_miss, 1);
    chk("R12 p1 miss", p1_miss, 1);
    chk("R12 p0 line", p0_fill_addr, mk_addr(50, 5, 0) >> OFF_W);
    chk("R12 p1 line", p1_fill_addr, mk_addr(60, 6, 0) >> OFF_W);
    @(negedge clk);
    drive_fill(0, mk_addr(50, 5, 0) >> OFF_W, 0);
    drive_fill(1, mk_addr(60, 6, 0) >> OFF_W, 1);
    @(negedge clk);
    drop_fill();
    chk("R12 p0 replay", p0_rdata, exp_word(mk_addr(50, 5, 0) >> OFF_W, 1, 0));
    chk("R12 p1 replay", p1_rdata, exp_word(mk_addr(60, 6, 0) >> OFF_W, 2, 1));
    chk("R12 both hit", {p0_hit, p1_hit}, 2'b11);

    // port 1 sweep over its own partition (R9)
    for (int s = 1; s < SETS; s++) begin
      if (s != 6) read(1, mk_addr(s + 40, s, 0), 1'b0, 1, "R9");
    end
    for (int s = 1; s < SETS; s++) begin
      for (int o = 0; o < WORDS; o++) begin
        if (s != 6) read(1, mk_addr(s + 40, s, o), 1'b1, 1, "R9");
      end
    end

    // back to shared: flushed, port 1 ignored again
    write_mode(1'b0);
    read(0, mk_addr(50, 5, 1), 1'b0, 0, "R11");
    @(negedge clk);
    drive_req(1, mk_addr(41, 1, 0));
    @(negedge clk);
    drop_req();
    chk("R7 p1 silent after return", {p1_hit, p1_miss, p1_fill_req}, 0);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule